// File: doc/BRIEF.md
# Multiprocessor Interrupt Controller

The block collects interrupt sources for a small multiprocessor system and presents each CPU with its own request line and a claim/complete register interface. Sources 0 to 31 are private: every CPU has its own copy of them, with its own input wires, configured through that CPU's local window. Sources 32 and up are shared peripheral inputs, configured through the global region and indexed as ID minus 32. Each source carries a 2-bit trigger type, an enable, a pending state and an in-service state.

Software reads a CPU's ready register to claim the best pending source. The source then stays in service until its ID is written to that CPU's completion register. A shared source is either pinned to one CPU or offered to every CPU; in the second case the first CPU to claim it takes it from the others. Any CPU can raise an inter-processor interrupt on a mask of CPUs by writing its signal register. The register port is a single-cycle read/write port, and read data returns one cycle after the request.

Top module: `mp_irq_ctrl`

## Requirements
- R1: After reset every irq_o bit is 0, the global control word reads 0 and every CPU's ready register (local offset 0x6C) reads 0x3FF.
- R2: A CPU's irq_o bit can be 1 only while bit 0 of the global control word (global offset 0x0) and bit 0 of that CPU's local control word (local offset 0x0) are both 1.
- R3: Trigger encoding 0 makes a source pending while its input is 1, and encoding 1 while its input is 0. The 2-bit field of index i sits in word i/16 at bits 2*(i mod 16); shared words start at global 0x100, private words at local 0x14, and reads return the written fields.
- R4: Encoding 2 latches pending on a 0-to-1 input change and encoding 3 on a 1-to-0 change; the latch holds after the input returns and clears when the source is claimed.
- R5: Writing an ID to local offset 0xA0 enables the source and to offset 0xA4 disables it; a disabled source never raises irq_o.
- R6: Among the sources that are pending, enabled and not in service for a CPU, the lowest ID is returned by that CPU's ready register; with none it returns 0x3FF.
- R7: Reading a valid ID from the ready register puts the source in service: it is not requested again until its ID is written to local offset 0xB4.
- R8: A level source that is still at its active level after completion is requested again; an edge source whose latch was cleared by the claim is not.
- R9: A shared source whose routing word (global 0x1000 + 4*(ID-32)) has bit 31 set is requested only at the CPU numbered in the low bits; the word reads back as written.
- R10: A routing word of 0 offers the shared source to every delivering CPU, and a claim by one of them removes the request from all others.
- R11: Writing local offset 0x60 with an ID in bits 3:0 and a CPU mask in bits 15:8 makes that private ID pending at every CPU in the mask and at no other; the claim clears it.
- R12: A private source's input, trigger field and enable belong to one CPU only; the same ID at another CPU is unaffected.
- R13: The global region is 0x8000 bytes, followed by one 0x1000-byte local window per CPU in CPU order; control words read back as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access request |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 16 | Byte address (word aligned) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| priv_irq_i | input | 128 | Private source inputs, bit c*32+i is source i of CPU c |
| shr_irq_i | input | 32 | Shared source inputs, bit k is source 32+k |
| irq_o | output | 4 | Per-CPU interrupt request |

## Verification
The assertions take for granted that only one register access happens per cycle, so a claim and a completion of the same source never fall in the same cycle, and that source inputs are already synchronous to clk_i. The bench drives all inputs at the falling edge through single-access tasks, keeps every input steady across each rising edge, and restores trigger fields, enables and inputs to their idle values after each case so that a source left at an active level cannot leak into the next case.

// File: rtl/mp_irq_pkg.sv
package mp_irq_pkg;
  localparam int unsigned ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'h3FF;

  localparam logic [31:0] GLB_SIZE  = 32'h8000;
  localparam logic [31:0] LOC_SIZE  = 32'h1000;
  localparam logic [31:0] GLB_CTRL  = 32'h0000;
  localparam logic [31:0] GLB_TRIG  = 32'h0100;
  localparam logic [31:0] GLB_ROUTE = 32'h1000;

  localparam logic [11:0] LOC_CTRL  = 12'h000;
  localparam logic [11:0] LOC_TRIG  = 12'h014;
  localparam logic [11:0] LOC_SIG   = 12'h060;
  localparam logic [11:0] LOC_READY = 12'h06C;
  localparam logic [11:0] LOC_SETEN = 12'h0A0;
  localparam logic [11:0] LOC_CLREN = 12'h0A4;
  localparam logic [11:0] LOC_DONE  = 12'h0B4;

  typedef enum logic [1:0] {
    TRG_LVL_HI = 2'd0,
    TRG_LVL_LO = 2'd1,
    TRG_RISE   = 2'd2,
    TRG_FALL   = 2'd3
  } trig_e;
endpackage

// File: rtl/mp_irq_src.sv
module mp_irq_src
  import mp_irq_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  trig_e trig_i,
  input  logic  in_i,
  input  logic  clr_i,
  output logic  pend_o
);
  logic prev_q, lat_q, edge_hit;

  always_comb begin
    case (trig_i)
      TRG_RISE: edge_hit = in_i & ~prev_q;
      TRG_FALL: edge_hit = ~in_i & prev_q;
      default:  edge_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      lat_q  <= 1'b0;
    end else begin
      prev_q <= in_i;
      // a new edge wins over a claim in the same cycle
      if (edge_hit)   lat_q <= 1'b1;
      else if (clr_i) lat_q <= 1'b0;
    end
  end

  assign pend_o = trig_i[1] ? lat_q : (in_i ^ trig_i[0]);
endmodule

// File: rtl/mp_irq_arb.sv
module mp_irq_arb
  import mp_irq_pkg::*;
#(
  parameter int unsigned N = 64
) (
  input  logic [N-1:0]    req_i,
  output logic            valid_o,
  output logic [ID_W-1:0] id_o
);
  always_comb begin
    valid_o = 1'b0;
    id_o    = NO_IRQ;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        valid_o = 1'b1;
        id_o    = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/mp_irq_ctrl.sv
module mp_irq_ctrl
  import mp_irq_pkg::*;
#(
  parameter int unsigned NUM_CPU  = 4,
  parameter int unsigned NUM_SRC  = 64,
  parameter int unsigned NUM_PRIV = 32,
  localparam int unsigned ADDR_W  = $clog2(GLB_SIZE + NUM_CPU * LOC_SIZE)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         req_i,
  input  logic                         we_i,
  input  logic [ADDR_W-1:0]            addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  input  logic [NUM_CPU*NUM_PRIV-1:0]  priv_irq_i,
  input  logic [NUM_SRC-NUM_PRIV-1:0]  shr_irq_i,
  output logic [NUM_CPU-1:0]           irq_o
);
  localparam int unsigned NUM_SHR    = NUM_SRC - NUM_PRIV;
  localparam int unsigned CPU_W      = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1;
  localparam int unsigned PIDX_W     = $clog2(NUM_PRIV);
  localparam int unsigned SIDX_W     = (NUM_SHR > 1) ? $clog2(NUM_SHR) : 1;
  localparam int unsigned PRIV_WORDS = (NUM_PRIV * 2 + 31) / 32;
  localparam int unsigned SHR_WORDS  = (NUM_SHR * 2 + 31) / 32;

  // ---------------- address decode ----------------
  logic [31:0]      a32, rel, win, gtw, ridx, ltw, sid;
  logic [11:0]      loff;
  logic             is_glb, loc_hit, g_trig_hit, g_route_hit, l_trig_hit;
  logic             wr, rd;
  logic [CPU_W-1:0] cpu_sel;

  assign a32     = 32'(addr_i);
  assign wr      = req_i & we_i;
  assign rd      = req_i & ~we_i;
  assign is_glb  = a32 < GLB_SIZE;
  assign rel     = a32 - GLB_SIZE;
  assign win     = rel >> 12;
  assign loc_hit = !is_glb && (win < NUM_CPU);
  assign cpu_sel = CPU_W'(win);
  assign loff    = a32[11:0];
  assign sid     = 32'(wdata_i[ID_W-1:0]);

  assign g_trig_hit  = is_glb && a32 >= GLB_TRIG && a32 < GLB_TRIG + 4 * SHR_WORDS;
  assign g_route_hit = is_glb && a32 >= GLB_ROUTE && a32 < GLB_ROUTE + 4 * NUM_SHR;
  assign l_trig_hit  = loc_hit && 32'(loff) >= 32'(LOC_TRIG) &&
                       32'(loff) < 32'(LOC_TRIG) + 4 * PRIV_WORDS;
  assign gtw  = (a32 - GLB_TRIG) >> 2;
  assign ridx = (a32 - GLB_ROUTE) >> 2;
  assign ltw  = (32'(loff) - 32'(LOC_TRIG)) >> 2;

  // ---------------- state ----------------
  logic                glb_en_q;
  logic [NUM_CPU-1:0]  loc_en_q;
  trig_e               priv_trig_q [NUM_CPU][NUM_PRIV];
  trig_e               shr_trig_q  [NUM_SHR];
  logic [NUM_SHR-1:0]  shr_fix_q;
  logic [CPU_W-1:0]    shr_tgt_q   [NUM_SHR];
  logic [NUM_PRIV-1:0] priv_en_q   [NUM_CPU];
  logic [NUM_PRIV-1:0] priv_isv_q  [NUM_CPU];
  logic [NUM_PRIV-1:0] priv_sw_q   [NUM_CPU];
  logic [NUM_SHR-1:0]  shr_en_q, shr_isv_q;
  logic [31:0]         rdata_q;

  // ---------------- arbitration ----------------
  logic [NUM_PRIV-1:0] priv_pend [NUM_CPU];
  logic [NUM_PRIV-1:0] priv_clr  [NUM_CPU];
  logic [NUM_SHR-1:0]  shr_pend, shr_clr;
  logic [ID_W-1:0]     arb_id [NUM_CPU];
  logic [NUM_CPU-1:0]  arb_valid;

  logic            rd_rdy, claim_v, claim_priv, claim_shr;
  logic            done_v, ipi_v;
  logic [ID_W-1:0] claim_id, done_id;

  assign rd_rdy     = rd && loc_hit && loff == LOC_READY;
  assign claim_id   = arb_id[cpu_sel];
  assign claim_v    = rd_rdy && arb_valid[cpu_sel];
  assign claim_priv = claim_v && 32'(claim_id) < NUM_PRIV;
  assign claim_shr  = claim_v && 32'(claim_id) >= NUM_PRIV;
  assign done_v     = wr && loc_hit && loff == LOC_DONE;
  assign done_id    = wdata_i[ID_W-1:0];
  assign ipi_v      = wr && loc_hit && loff == LOC_SIG;

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
    logic [NUM_SHR-1:0] route_ok;
    logic [NUM_SRC-1:0] cand;
    logic               deliver;

    for (genvar i = 0; i < NUM_PRIV; i++) begin : g_priv
      assign priv_clr[c][i] = claim_priv && cpu_sel == CPU_W'(c) &&
                              claim_id == ID_W'(i);
      mp_irq_src u_src (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .trig_i(priv_trig_q[c][i]),
        .in_i  (priv_irq_i[c*NUM_PRIV+i]),
        .clr_i (priv_clr[c][i]),
        .pend_o(priv_pend[c][i])
      );
    end

    for (genvar k = 0; k < NUM_SHR; k++) begin : g_route
      assign route_ok[k] = !shr_fix_q[k] || shr_tgt_q[k] == CPU_W'(c);
    end

    assign deliver = glb_en_q & loc_en_q[c];
    assign cand = {shr_pend & shr_en_q & ~shr_isv_q & route_ok,
                   (priv_pend[c] | priv_sw_q[c]) & priv_en_q[c] & ~priv_isv_q[c]}
                  & {NUM_SRC{deliver}};

    mp_irq_arb #(.N(NUM_SRC)) u_arb (
      .req_i  (cand),
      .valid_o(arb_valid[c]),
      .id_o   (arb_id[c])
    );
  end

  for (genvar k = 0; k < NUM_SHR; k++) begin : g_shr
    assign shr_clr[k] = claim_shr && claim_id == ID_W'(NUM_PRIV + k);
    mp_irq_src u_src (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .trig_i(shr_trig_q[k]),
      .in_i  (shr_irq_i[k]),
      .clr_i (shr_clr[k]),
      .pend_o(shr_pend[k])
    );
  end

  assign irq_o = arb_valid;

  // ---------------- register writes, claim, complete ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      glb_en_q  <= 1'b0;
      loc_en_q  <= '0;
      shr_fix_q <= '0;
      shr_en_q  <= '0;
      shr_isv_q <= '0;
      for (int k = 0; k < NUM_SHR; k++) begin
        shr_trig_q[k] <= TRG_LVL_HI;
        shr_tgt_q[k]  <= '0;
      end
      for (int c = 0; c < NUM_CPU; c++) begin
        priv_en_q[c]  <= '0;
        priv_isv_q[c] <= '0;
        priv_sw_q[c]  <= '0;
        for (int i = 0; i < NUM_PRIV; i++) priv_trig_q[c][i] <= TRG_LVL_HI;
      end
    end else begin
      if (wr && is_glb && a32 == GLB_CTRL) glb_en_q <= wdata_i[0];
      if (wr && g_trig_hit) begin
        for (int k = 0; k < NUM_SHR; k++)
          if (k / 16 == gtw) shr_trig_q[k] <= trig_e'(wdata_i[2*(k%16)+:2]);
      end
      if (wr && g_route_hit) begin
        for (int k = 0; k < NUM_SHR; k++)
          if (k == ridx) begin
            shr_fix_q[k] <= wdata_i[31];
            shr_tgt_q[k] <= wdata_i[CPU_W-1:0];
          end
      end
      if (wr && loc_hit && loff == LOC_CTRL) loc_en_q[cpu_sel] <= wdata_i[0];
      if (wr && l_trig_hit) begin
        for (int i = 0; i < NUM_PRIV; i++)
          if (i / 16 == ltw) priv_trig_q[cpu_sel][i] <= trig_e'(wdata_i[2*(i%16)+:2]);
      end
      if (wr && loc_hit && (loff == LOC_SETEN || loff == LOC_CLREN)) begin
        if (sid < NUM_PRIV)
          priv_en_q[cpu_sel][PIDX_W'(sid)] <= (loff == LOC_SETEN);
        else if (sid < NUM_SRC)
          shr_en_q[SIDX_W'(sid - NUM_PRIV)] <= (loff == LOC_SETEN);
      end
      if (ipi_v) begin
        for (int t = 0; t < NUM_CPU; t++)
          if (wdata_i[8+t]) priv_sw_q[t][PIDX_W'(wdata_i[3:0])] <= 1'b1;
      end
      if (claim_priv) begin
        priv_isv_q[cpu_sel][PIDX_W'(claim_id)] <= 1'b1;
        priv_sw_q[cpu_sel][PIDX_W'(claim_id)]  <= 1'b0;
      end
      if (claim_shr) shr_isv_q[SIDX_W'(32'(claim_id) - NUM_PRIV)] <= 1'b1;
      if (done_v) begin
        if (sid < NUM_PRIV)
          priv_isv_q[cpu_sel][PIDX_W'(sid)] <= 1'b0;
        else if (sid < NUM_SRC)
          shr_isv_q[SIDX_W'(sid - NUM_PRIV)] <= 1'b0;
      end
    end
  end

  // ---------------- read data ----------------
  logic [31:0] rd_val;
  always_comb begin
    rd_val = '0;
    if (is_glb) begin
      if (a32 == GLB_CTRL) rd_val[0] = glb_en_q;
      if (g_trig_hit) begin
        for (int k = 0; k < NUM_SHR; k++)
          if (k / 16 == gtw) rd_val[2*(k%16)+:2] = shr_trig_q[k];
      end
      if (g_route_hit) begin
        for (int k = 0; k < NUM_SHR; k++)
          if (k == ridx) rd_val = {shr_fix_q[k], {(31 - CPU_W){1'b0}}, shr_tgt_q[k]};
      end
    end else if (loc_hit) begin
      if (loff == LOC_CTRL)  rd_val[0] = loc_en_q[cpu_sel];
      if (loff == LOC_READY) rd_val = 32'(claim_id);
      if (l_trig_hit) begin
        for (int i = 0; i < NUM_PRIV; i++)
          if (i / 16 == ltw) rd_val[2*(i%16)+:2] = priv_trig_q[cpu_sel][i];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  rdata_q <= '0;
    else if (rd)  rdata_q <= rd_val;
  end
  assign rdata_o = rdata_q;

  logic unused_bits;
  assign unused_bits = ^{wdata_i[30:16], wdata_i[7:4], rel[11:0]};
endmodule

// File: rtl/mp_irq_chk.sv
module mp_irq_chk
  import mp_irq_pkg::*;
#(
  parameter int unsigned NUM_CPU  = 4,
  parameter int unsigned NUM_SRC  = 64,
  parameter int unsigned NUM_PRIV = 32
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         glb_en_q,
  input logic [NUM_CPU-1:0]           loc_en_q,
  input logic [NUM_CPU-1:0]           irq_o,
  input logic                         claim_v,
  input logic [ID_W-1:0]              claim_id,
  input logic                         done_v,
  input logic [ID_W-1:0]              done_id,
  input logic [NUM_SRC-NUM_PRIV-1:0]  shr_isv_q,
  input logic                         rd_rdy,
  input logic [31:0]                  rdata_o
);
  localparam int unsigned NUM_SHR = NUM_SRC - NUM_PRIV;
  localparam int unsigned SIDX_W  = (NUM_SHR > 1) ? $clog2(NUM_SHR) : 1;

  logic              claim_shr_q, done_shr_q, rd_rdy_q;
  logic [SIDX_W-1:0] cidx_q, didx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      claim_shr_q <= 1'b0;
      done_shr_q  <= 1'b0;
      rd_rdy_q    <= 1'b0;
      cidx_q      <= '0;
      didx_q      <= '0;
    end else begin
      claim_shr_q <= claim_v && 32'(claim_id) >= NUM_PRIV && 32'(claim_id) < NUM_SRC;
      done_shr_q  <= done_v && 32'(done_id) >= NUM_PRIV && 32'(done_id) < NUM_SRC;
      rd_rdy_q    <= rd_rdy;
      cidx_q      <= SIDX_W'(32'(claim_id) - NUM_PRIV);
      didx_q      <= SIDX_W'(32'(done_id) - NUM_PRIV);
    end
  end

  // R2
  glb_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glb_en_q |-> irq_o == '0);

  // R2
  loc_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o & ~loc_en_q) == '0);

  // R7
  claim_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_shr_q |-> shr_isv_q[cidx_q]);

  // R7
  done_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_shr_q |-> !shr_isv_q[didx_q]);

  // R6
  ready_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_rdy_q |-> (rdata_o == 32'h3FF || rdata_o < NUM_SRC));
endmodule

bind mp_irq_ctrl mp_irq_chk #(
  .NUM_CPU (NUM_CPU),
  .NUM_SRC (NUM_SRC),
  .NUM_PRIV(NUM_PRIV)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .glb_en_q (glb_en_q),
  .loc_en_q (loc_en_q),
  .irq_o    (irq_o),
  .claim_v  (claim_v),
  .claim_id (claim_id),
  .done_v   (done_v),
  .done_id  (done_id),
  .shr_isv_q(shr_isv_q),
  .rd_rdy   (rd_rdy),
  .rdata_o  (rdata_o)
);

// File: tb/mp_irq_ctrl_test.sv
module mp_irq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NCPU = 4;
  localparam int NPRV = 32;
  localparam int NSHR = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [15:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NCPU*NPRV-1:0] priv = '0;
  logic [NSHR-1:0]   shr = '0;
  logic [NCPU-1:0]   irq;

  int checks = 0, fails = 0;
  bit done_flag = 0;

  mp_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .priv_irq_i(priv), .shr_irq_i(shr),
    .irq_o(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [15:0] loc(input int c, input int off);
    return 16'(32'h8000 + 32'h1000 * c + off);
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic bus_wr(input logic [15:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_rd(input logic [15:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    @(negedge clk);
    req = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    chk("R1 irq after reset", 32'(irq), 0);
    bus_rd(16'h0000, d); chk("R1 global ctrl", d, 0);
    for (int c = 0; c < NCPU; c++) begin
      bus_rd(loc(c, 'h6C), d); chk("R1 ready idle", d, 32'h3FF);
    end

    // R2 global and local gating, private source 3 on cpu0
    bus_wr(loc(0, 'hA0), 3);
    bus_wr(loc(0, 'h0), 1);
    priv[3] = 1'b1; tick();
    chk("R2 global off", 32'(irq), 0);
    bus_wr(16'h0000, 1);
    chk("R2 both on", 32'(irq), 1);
    bus_wr(loc(0, 'h0), 0);
    chk("R2 local off", 32'(irq), 0);
    bus_wr(loc(0, 'h0), 1);
    bus_rd(loc(0, 'h6C), d); chk("R7 claim priv 3", d, 3);
    priv[3] = 1'b0;
    bus_wr(loc(0, 'hB4), 3);
    bus_wr(loc(0, 'hA4), 3);
    for (int c = 1; c < NCPU; c++) bus_wr(loc(c, 'h0), 1);

    // R13 control readback
    bus_rd(16'h0000, d); chk("R13 global ctrl readback", d, 1);
    bus_rd(loc(3, 'h0), d); chk("R13 local ctrl cpu3 readback", d, 1);

    // shared sweep: every source, all encodings, all fixed targets
    for (int j = 0; j < NSHR; j++) begin
      int enc, cpu, oth;
      logic inact;
      logic [31:0] tw;
      enc = j % 4;
      cpu = (j / 4) % 4;
      oth = (cpu + 1) % 4;
      inact = (enc == 1 || enc == 3);
      tw = 32'(enc) << (2 * (j % 16));
      shr[j] = inact; tick();
      bus_wr(16'(32'h100 + 4 * (j / 16)), tw);
      bus_rd(16'(32'h100 + 4 * (j / 16)), d); chk("R3 trig field placement", d, tw);
      bus_wr(16'(32'h1000 + 4 * j), 32'h8000_0000 | 32'(cpu));
      bus_rd(16'(32'h1000 + 4 * j), d); chk("R9 route readback", d, 32'h8000_0000 | 32'(cpu));
      bus_wr(loc(cpu, 'hA0), 32'(32 + j));
      tick();
      chk(enc < 2 ? "R3 inactive level" : "R4 no edge yet", 32'(irq), 0);
      shr[j] = ~inact; tick();
      chk("R9 fixed target only", 32'(irq), 32'(1 << cpu));
      if (enc >= 2) begin
        shr[j] = inact; tick();
        chk("R4 edge latched", 32'(irq), 32'(1 << cpu));
      end
      bus_rd(loc(oth, 'h6C), d); chk("R9 other cpu ready", d, 32'h3FF);
      bus_rd(loc(cpu, 'h6C), d); chk("R7 claim shared", d, 32'(32 + j));
      chk("R7 in service no request", 32'(irq), 0);
      bus_rd(loc(cpu, 'h6C), d); chk("R7 no second claim", d, 32'h3FF);
      bus_wr(loc(cpu, 'hB4), 32'(32 + j));
      chk("R8 after completion", 32'(irq), (enc < 2) ? 32'(1 << cpu) : 0);
      bus_wr(loc(cpu, 'hA4), 32'(32 + j));
      chk("R5 clear enable", 32'(irq), 0);
      bus_wr(16'(32'h100 + 4 * (j / 16)), 0);
      shr[j] = 1'b0; tick();
    end

    // R12 private separation and private trigger via local window
    for (int c = 0; c < NCPU; c++) bus_wr(loc(c, 'hA0), 7);
    priv[2*NPRV+7] = 1'b1; tick();
    chk("R12 private input one cpu", 32'(irq), 32'b0100);
    bus_rd(loc(2, 'h6C), d); chk("R12 claim private 7", d, 7);
    priv[2*NPRV+7] = 1'b0;
    bus_wr(loc(2, 'hB4), 7);
    for (int c = 0; c < NCPU; c++) bus_wr(loc(c, 'hA4), 7);
    chk("R5 private cleared", 32'(irq), 0);
    bus_wr(loc(1, 'h18), 32'h200);
    bus_rd(loc(1, 'h18), d); chk("R12 private trig readback", d, 32'h200);
    bus_rd(loc(0, 'h18), d); chk("R12 other cpu trig untouched", d, 0);
    bus_wr(loc(1, 'hA0), 20);
    bus_wr(loc(0, 'hA0), 20);
    priv[1*NPRV+20] = 1'b1; priv[0*NPRV+20] = 1'b1; tick();
    priv[1*NPRV+20] = 1'b0; priv[0*NPRV+20] = 1'b0; tick();
    chk("R12 private rising at cpu1 only", 32'(irq), 32'b0010);
    bus_rd(loc(1, 'h6C), d); chk("R4 claim edge 20", d, 20);
    bus_wr(loc(1, 'hB4), 20);
    chk("R8 edge not redelivered", 32'(irq), 0);
    bus_wr(loc(1, 'hA4), 20);
    bus_wr(loc(0, 'hA4), 20);
    bus_wr(loc(1, 'h18), 0);

    // R6 lowest ID first at cpu1
    bus_wr(16'(32'h1000 + 4 * 8), 32'h8000_0001);
    bus_wr(16'(32'h1000 + 4 * 18), 32'h8000_0001);
    bus_wr(loc(1, 'hA0), 50);
    bus_wr(loc(1, 'hA0), 40);
    bus_wr(loc(1, 'hA0), 5);
    shr[8] = 1'b1; shr[18] = 1'b1; priv[1*NPRV+5] = 1'b1; tick();
    bus_rd(loc(1, 'h6C), d); chk("R6 first lowest", d, 5);
    bus_rd(loc(1, 'h6C), d); chk("R6 second", d, 40);
    bus_rd(loc(1, 'h6C), d); chk("R6 third", d, 50);
    bus_rd(loc(1, 'h6C), d); chk("R6 none left", d, 32'h3FF);
    shr[8] = 1'b0; shr[18] = 1'b0; priv[1*NPRV+5] = 1'b0;
    bus_wr(loc(1, 'hB4), 5); bus_wr(loc(1, 'hB4), 40); bus_wr(loc(1, 'hB4), 50);
    bus_wr(loc(1, 'hA4), 5); bus_wr(loc(1, 'hA4), 40); bus_wr(loc(1, 'hA4), 50);
    chk("R6 all released", 32'(irq), 0);

    // R10 automatic delivery of shared 33
    bus_wr(16'(32'h1000 + 4 * 1), 0);
    bus_wr(loc(3, 'hA0), 33);
    shr[1] = 1'b1; tick();
    chk("R10 offered to all", 32'(irq), 32'hF);
    bus_rd(loc(2, 'h6C), d); chk("R10 claim by cpu2", d, 33);
    chk("R10 removed elsewhere", 32'(irq), 0);
    bus_rd(loc(0, 'h6C), d); chk("R10 cpu0 sees none", d, 32'h3FF);
    shr[1] = 1'b0;
    bus_wr(loc(2, 'hB4), 33);
    bus_wr(loc(2, 'hA4), 33);
    chk("R10 idle", 32'(irq), 0);

    // R11 inter-processor interrupt id 15 to cpus 1 and 3
    for (int c = 1; c < NCPU; c++) bus_wr(loc(c, 'hA0), 15);
    bus_wr(loc(0, 'h60), (32'b1010 << 8) | 32'd15);
    chk("R11 ipi targets", 32'(irq), 32'b1010);
    bus_rd(loc(1, 'h6C), d); chk("R11 cpu1 claim", d, 15);
    bus_rd(loc(3, 'h6C), d); chk("R11 cpu3 claim", d, 15);
    bus_rd(loc(2, 'h6C), d); chk("R11 cpu2 untouched", d, 32'h3FF);
    bus_wr(loc(1, 'hB4), 15);
    bus_wr(loc(3, 'hB4), 15);
    chk("R11 cleared by claim", 32'(irq), 0);

    finish_run();
  end
endmodule